// File: doc/BRIEF.md
# Ethernet Pause Frame Flow Controller

This block sits beside a full-duplex Ethernet receiver and transmitter. It watches the received frame stream one nibble per clock. Each octet arrives as two nibbles, and the low nibble comes first. The block recognises MAC control pause frames that are addressed to this station. From a recognised frame it takes the requested pause period, counted in slot times, and holds off the start of normal transmit frames for that long.

Two state machines do the work. The receive parser has three states: `P_IDLE`, `P_HDR` and `P_TAIL`. Its transitions are:
- **start**: `rx_sof` moves any state to `P_HDR`.
- **header done**: the 18th octet moves `P_HDR` to `P_TAIL`.
- **end**: `rx_eof` moves `P_HDR` or `P_TAIL` back to `P_IDLE`.

The parser can commit a pause value only on the end transition out of `P_TAIL`. The pause timer has two states: `T_IDLE` and `T_HOLD`. Its transitions are:
- **load**: a commit with a non-zero period moves either state to `T_HOLD`.
- **release**: a commit with a zero period moves either state to `T_IDLE`.
- **expire**: the last slot count running out moves `T_HOLD` to `T_IDLE`.

A prescaler decrements the slot count once every `SLOT_CLKS` clocks, which is 128 by default (512 bit times). While the timer holds, normal frame starts are refused. A single out-of-sequence frame start is still granted during each pause.

Top module: `pfc_flow_ctrl`

## Requirements
- R1: Octets are assembled from two successive valid nibbles, and the first nibble of each pair is bits [3:0]. The first nibble of a frame is marked by `rx_sof` together with `rx_nib_vld`.
- R2: A frame is treated as a pause request only if octets 12–13 equal 0x88,0x08 and octets 14–15 equal 0x00,0x01. Octets are counted from 0 at the first destination address octet.
- R3: The destination (octets 0–5) must be one of three addresses: 01-80-C2-00-00-01, FF-FF-FF-FF-FF-FF, or the station address. The station address is sent as `cfg_station_addr[47:40]` first. Any other destination is ignored.
- R4: The pause period is octets 16 (high byte) and 17 (low byte).
- R5: A commit needs the header complete and at least 64 octets received before `rx_eof`. A shorter frame is ignored.
- R6: A commit happens only when `rx_frame_ok` is high in the `rx_eof` cycle.
- R7: When `cfg_fc_en` is low, pause frames have no effect on `tx_pause`.
- R8: A committed non-zero period N raises `tx_pause` after the clock edge that samples `rx_eof`. It stays high for exactly N×128 clocks.
- R9: A commit during a pause replaces the remaining time with the new period, measured from the new commit edge. This includes a commit that lands on the expiry edge.
- R10: A committed period of zero clears `tx_pause` at the commit edge. With no pause active, it has no visible effect.
- R11: `tx_norm_ok` equals `tx_norm_req` while `tx_pause` is low, and is 0 while `tx_pause` is high.
- R12: `tx_oos_ok` follows `tx_oos_req` outside a pause. During one pause, it is granted for only the first requesting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fc_en | input | 1 | Flow-control enable |
| cfg_station_addr | input | 48 | Own unicast address, bits [47:40] sent first |
| rx_nib | input | 4 | Receive nibble |
| rx_nib_vld | input | 1 | Nibble valid |
| rx_sof | input | 1 | First nibble of a frame |
| rx_eof | input | 1 | End-of-frame strobe, a cycle of its own after the last nibble |
| rx_frame_ok | input | 1 | CRC good, sampled with `rx_eof` |
| tx_norm_req | input | 1 | Request to start a normal frame |
| tx_oos_req | input | 1 | Request to start an out-of-sequence frame |
| tx_pause | output | 1 | Pause in progress |
| tx_norm_ok | output | 1 | Normal frame start granted |
| tx_oos_ok | output | 1 | Out-of-sequence frame start granted |

## Verification
Two functions can fall on the same clock edge: the timer expiring and a new commit arriving. The bench provokes this by committing a period of 2 and then ending a second pause frame exactly 256 clocks after the first commit edge. The bench then checks that `tx_pause` forms one unbroken run of 256 plus 128 clocks, rather than dropping for a cycle. A second overlap is a zero-period commit during a running pause; it must cut the run to 129 clocks.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic [1:0] {P_IDLE, P_HDR, P_TAIL} prs_state_t;
    typedef enum logic {T_IDLE, T_HOLD} tmr_state_t;

    localparam logic [47:0] CTRL_MCAST  = 48'h0180C2000001;
    localparam logic [15:0] CTRL_ETYPE  = 16'h8808;
    localparam logic [15:0] PAUSE_OPC   = 16'h0001;
endpackage

// File: rtl/pfc_rx_parser.sv
module pfc_rx_parser
    import pfc_pkg::*;
#(
    parameter int PERIOD_W   = 16,
    parameter int MIN_OCTETS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_fc_en,
    input  logic [47:0]         cfg_station_addr,
    input  logic [3:0]          rx_nib,
    input  logic                rx_nib_vld,
    input  logic                rx_sof,
    input  logic                rx_eof,
    input  logic                rx_frame_ok,
    output logic                commit,
    output logic [PERIOD_W-1:0] commit_val
);
    localparam int CNT_W = $clog2(MIN_OCTETS) + 1;
    localparam logic [CNT_W-1:0] IDX_TYPE_HI = CNT_W'(12);
    localparam logic [CNT_W-1:0] IDX_TYPE_LO = CNT_W'(13);
    localparam logic [CNT_W-1:0] IDX_OPC_HI  = CNT_W'(14);
    localparam logic [CNT_W-1:0] IDX_OPC_LO  = CNT_W'(15);
    localparam logic [CNT_W-1:0] IDX_PRM_HI  = CNT_W'(16);
    localparam logic [CNT_W-1:0] IDX_PRM_LO  = CNT_W'(17);
    localparam logic [CNT_W-1:0] IDX_DA_END  = CNT_W'(6);
    localparam logic [CNT_W-1:0] MIN_CNT     = CNT_W'(MIN_OCTETS);

    prs_state_t          state;
    logic                phase;
    logic [3:0]          lo_nib;
    logic [CNT_W-1:0]    oct_cnt;
    logic                m_mc, m_bc, m_own, m_type, m_op;
    logic [15:0]         prm;
    logic [7:0]          octet;
    logic                octet_done;

    assign octet      = {rx_nib, lo_nib};
    assign octet_done = (state != P_IDLE) && rx_nib_vld && phase && !rx_sof;

    function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [CNT_W-1:0] i);
        return a[(5 - int'(i)) * 8 +: 8];
    endfunction

    // state register and per-octet field capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= P_IDLE;
            phase   <= 1'b0;
            lo_nib  <= '0;
            oct_cnt <= '0;
            m_mc    <= 1'b0;
            m_bc    <= 1'b0;
            m_own   <= 1'b0;
            m_type  <= 1'b0;
            m_op    <= 1'b0;
            prm     <= '0;
        end else if (rx_sof && rx_nib_vld) begin
            state   <= P_HDR;
            phase   <= 1'b1;
            lo_nib  <= rx_nib;
            oct_cnt <= '0;
            m_mc    <= 1'b1;
            m_bc    <= 1'b1;
            m_own   <= 1'b1;
            m_type  <= 1'b1;
            m_op    <= 1'b1;
        end else if (rx_eof) begin
            state <= P_IDLE;
            phase <= 1'b0;
        end else if (state != P_IDLE && rx_nib_vld) begin
            if (!phase) begin
                lo_nib <= rx_nib;
                phase  <= 1'b1;
            end else begin
                phase <= 1'b0;
                if (oct_cnt != '1)
                    oct_cnt <= oct_cnt + 1'b1;
                if (oct_cnt < IDX_DA_END) begin
                    m_mc  <= m_mc  && (octet == addr_byte(CTRL_MCAST, oct_cnt));
                    m_bc  <= m_bc  && (octet == 8'hFF);
                    m_own <= m_own && (octet == addr_byte(cfg_station_addr, oct_cnt));
                end
                unique case (state)
                    P_HDR: begin
                        if (oct_cnt == IDX_TYPE_HI) m_type <= m_type && (octet == CTRL_ETYPE[15:8]);
                        if (oct_cnt == IDX_TYPE_LO) m_type <= m_type && (octet == CTRL_ETYPE[7:0]);
                        if (oct_cnt == IDX_OPC_HI)  m_op   <= m_op   && (octet == PAUSE_OPC[15:8]);
                        if (oct_cnt == IDX_OPC_LO)  m_op   <= m_op   && (octet == PAUSE_OPC[7:0]);
                        if (oct_cnt == IDX_PRM_HI)  prm[15:8] <= octet;
                        if (oct_cnt == IDX_PRM_LO) begin
                            prm[7:0] <= octet;
                            state    <= P_TAIL;
                        end
                    end
                    P_TAIL: ;
                    default: ;
                endcase
            end
        end
    end

    // outputs: commit only on the end transition out of P_TAIL
    always_comb begin
        commit     = rx_eof && (state == P_TAIL) && (oct_cnt >= MIN_CNT) &&
                     (m_mc || m_bc || m_own) && m_type && m_op &&
                     rx_frame_ok && cfg_fc_en;
        commit_val = PERIOD_W'(prm);
    end

    AST_TAIL_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == P_TAIL) |-> (oct_cnt > IDX_PRM_LO)); // R5
    AST_COMMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cfg_fc_en && rx_frame_ok && $past(rx_nib_vld))); // R6
endmodule

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer
    import pfc_pkg::*;
#(
    parameter int PERIOD_W  = 16,
    parameter int SLOT_CLKS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [PERIOD_W-1:0] load_val,
    output logic                pause
);
    localparam int PRE_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOT_CLKS - 1);
    localparam logic [PERIOD_W-1:0] ONE_SLOT = PERIOD_W'(1);

    tmr_state_t          state;
    logic [PERIOD_W-1:0] slot_cnt;
    logic [PRE_W-1:0]    pre_cnt;

    // state register: load and release take priority over expire
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= T_IDLE;
            slot_cnt <= '0;
            pre_cnt  <= '0;
        end else if (load_en) begin
            pre_cnt  <= '0;
            slot_cnt <= load_val;
            state    <= (load_val == '0) ? T_IDLE : T_HOLD;
        end else begin
            unique case (state)
                T_IDLE: pre_cnt <= '0;
                T_HOLD: begin
                    if (pre_cnt == PRE_LAST) begin
                        pre_cnt  <= '0;
                        slot_cnt <= slot_cnt - 1'b1;
                        if (slot_cnt == ONE_SLOT)
                            state <= T_IDLE;
                    end else begin
                        pre_cnt <= pre_cnt + 1'b1;
                    end
                end
                default: state <= T_IDLE;
            endcase
        end
    end

    always_comb pause = (state == T_HOLD);

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (slot_cnt == $past(load_val))); // R9
    AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_val == '0) |=> !pause); // R10
    AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pause |-> (slot_cnt != '0)); // R8
    AST_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !load_en) |=> (slot_cnt <= $past(slot_cnt))); // R8
endmodule

// File: rtl/pfc_flow_ctrl.sv
module pfc_flow_ctrl
    import pfc_pkg::*;
#(
    parameter int PERIOD_W   = 16,
    parameter int SLOT_CLKS  = 128,
    parameter int MIN_OCTETS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_fc_en,
    input  logic [47:0] cfg_station_addr,
    input  logic [3:0]  rx_nib,
    input  logic        rx_nib_vld,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_frame_ok,
    input  logic        tx_norm_req,
    input  logic        tx_oos_req,
    output logic        tx_pause,
    output logic        tx_norm_ok,
    output logic        tx_oos_ok
);
    logic                commit;
    logic [PERIOD_W-1:0] commit_val;
    logic                oos_used;

    pfc_rx_parser #(.PERIOD_W(PERIOD_W), .MIN_OCTETS(MIN_OCTETS)) i_parser (
        .clk(clk), .rst_n(rst_n), .cfg_fc_en(cfg_fc_en),
        .cfg_station_addr(cfg_station_addr), .rx_nib(rx_nib),
        .rx_nib_vld(rx_nib_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_frame_ok(rx_frame_ok), .commit(commit), .commit_val(commit_val)
    );

    pfc_pause_timer #(.PERIOD_W(PERIOD_W), .SLOT_CLKS(SLOT_CLKS)) i_timer (
        .clk(clk), .rst_n(rst_n), .load_en(commit), .load_val(commit_val),
        .pause(tx_pause)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            oos_used <= 1'b0;
        else if (!tx_pause)
            oos_used <= 1'b0;
        else if (tx_oos_req)
            oos_used <= 1'b1;
    end

    always_comb begin
        tx_norm_ok = tx_norm_req && !tx_pause;
        tx_oos_ok  = tx_oos_req && (!tx_pause || !oos_used);
    end

    AST_PAUSE_FROM_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> $past(rx_eof && cfg_fc_en)); // R7
    AST_OOS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pause && $past(tx_pause) && $past(tx_oos_ok)) |-> !tx_oos_ok); // R12
endmodule

// File: tb/test_pfc_flow_ctrl.sv
module test_pfc_flow_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT = 128;
    localparam logic [47:0] OWN  = 48'h02A1B2C3D4E5;
    localparam logic [47:0] MC   = 48'h0180C2000001;
    localparam logic [47:0] BC   = 48'hFFFFFFFFFFFF;
    localparam logic [47:0] OTHR = 48'h02A1B2C3D4E6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_fc_en = 1'b1;
    logic [3:0] rx_nib = '0;
    logic rx_nib_vld = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_frame_ok = 1'b0;
    logic tx_norm_req = 1'b0, tx_oos_req = 1'b0;
    logic tx_pause, tx_norm_ok, tx_oos_ok;

    int n_cmp = 0, n_bad = 0;
    int runs = 0, run_cur = 0, last_run = 0, cyc = 0;
    logic [47:0] f_da;
    logic [15:0] f_ty, f_op, f_pr;

    pfc_flow_ctrl i_pfc_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_fc_en(cfg_fc_en), .cfg_station_addr(OWN),
        .rx_nib(rx_nib), .rx_nib_vld(rx_nib_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_frame_ok(rx_frame_ok), .tx_norm_req(tx_norm_req), .tx_oos_req(tx_oos_req),
        .tx_pause(tx_pause), .tx_norm_ok(tx_norm_ok), .tx_oos_ok(tx_oos_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // pause run-length monitor: value just before each edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (tx_pause) run_cur = run_cur + 1;
            else if (run_cur > 0) begin
                last_run = run_cur;
                runs = runs + 1;
                run_cur = 0;
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 190000) begin
                n_bad = n_bad + 1;
                $display("FAIL watchdog: act %0d cycles exp < 190000", cyc);
                finish_run();
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] oct(input int i);
        if (i < 6)  return f_da[(5 - i) * 8 +: 8];
        if (i < 12) return 8'(8'h10 + i);
        if (i == 12) return f_ty[15:8];
        if (i == 13) return f_ty[7:0];
        if (i == 14) return f_op[15:8];
        if (i == 15) return f_op[7:0];
        if (i == 16) return f_pr[15:8];
        if (i == 17) return f_pr[7:0];
        return 8'(i * 7);
    endfunction

    task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                        input logic [15:0] pr, input int nocts, input logic good, input int gap);
        f_da = da; f_ty = ty; f_op = op; f_pr = pr;
        for (int g = 0; g < gap; g++) @(negedge clk);
        for (int k = 0; k < 2 * nocts; k++) begin
            logic [7:0] b;
            b = oct(k / 2);
            rx_nib_vld = 1'b1;
            rx_sof = (k == 0);
            rx_nib = (k % 2 == 0) ? b[3:0] : b[7:4];
            @(negedge clk);
        end
        rx_nib_vld = 1'b0; rx_sof = 1'b0;
        rx_eof = 1'b1; rx_frame_ok = good;
        @(negedge clk);
        rx_eof = 1'b0; rx_frame_ok = 1'b0;
    endtask

    task automatic wait_run(input int base, input string tag, input int exp);
        for (int w = 0; w < 40000 && runs == base; w++) @(negedge clk);
        chk(runs == base + 1, tag, runs - base, 1);
        chk(last_run == exp, tag, last_run, exp);
    endtask

    task automatic expect_none(input string tag);
        int base;
        base = runs;
        for (int w = 0; w < 20; w++) @(negedge clk);
        chk(runs == base && !tx_pause, tag, runs - base + int'(tx_pause), 0);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        tx_norm_req = 1'b1; tx_oos_req = 1'b1;
        #1;
        chk(tx_pause == 1'b0, "reset tx_pause", int'(tx_pause), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_norm_ok == 1'b1, "R11 idle norm grant", int'(tx_norm_ok), 1);
        chk(tx_oos_ok == 1'b1, "R12 idle oos grant", int'(tx_oos_ok), 1);
        tx_norm_req = 1'b0; tx_oos_req = 1'b0;

        // R3 R8 sweep over destinations and periods
        for (int d = 0; d < 3; d++) begin
            for (int v = 1; v <= 3; v++) begin
                base = runs;
                send((d == 0) ? MC : (d == 1) ? BC : OWN, 16'h8808, 16'h0001, 16'(v), 64, 1'b1, 0);
                wait_run(base, "R3/R8 dest sweep run length", v * SLOT);
            end
        end

        // R1 R4: period 0x0002 distinguishes nibble and byte order
        base = runs;
        send(MC, 16'h8808, 16'h0001, 16'h0002, 64, 1'b1, 0);
        wait_run(base, "R1/R4 octet order", 2 * SLOT);

        // rejections
        send(OTHR, 16'h8808, 16'h0001, 16'h0001, 64, 1'b1, 0);
        expect_none("R3 foreign unicast ignored");
        send(MC, 16'h8809, 16'h0001, 16'h0001, 64, 1'b1, 0);
        expect_none("R2 wrong type ignored");
        send(MC, 16'h8808, 16'h0002, 16'h0001, 64, 1'b1, 0);
        expect_none("R2 wrong opcode ignored");
        send(MC, 16'h8808, 16'h0001, 16'h0001, 63, 1'b1, 0);
        expect_none("R5 short frame ignored");
        send(MC, 16'h8808, 16'h0001, 16'h0001, 10, 1'b1, 0);
        expect_none("R5 truncated header ignored");
        send(MC, 16'h8808, 16'h0001, 16'h0001, 64, 1'b0, 0);
        expect_none("R6 bad CRC ignored");
        cfg_fc_en = 1'b0;
        send(MC, 16'h8808, 16'h0001, 16'h0001, 64, 1'b1, 0);
        expect_none("R7 disabled ignored");
        cfg_fc_en = 1'b1;
        send(BC, 16'h8808, 16'h0001, 16'h0000, 64, 1'b1, 0);
        expect_none("R10 zero with no pause");

        // R9 reload replaces, frames back to back
        base = runs;
        send(MC, 16'h8808, 16'h0001, 16'h0003, 64, 1'b1, 0);
        send(MC, 16'h8808, 16'h0001, 16'h0001, 64, 1'b1, 0);
        wait_run(base, "R9 reload replaces", 129 + SLOT);

        // R9 reload on the expiry edge
        base = runs;
        send(MC, 16'h8808, 16'h0001, 16'h0002, 64, 1'b1, 0);
        send(MC, 16'h8808, 16'h0001, 16'h0001, 64, 1'b1, 127);
        wait_run(base, "R9 reload on expiry edge", 2 * SLOT + SLOT);

        // R10 zero period releases a running pause
        base = runs;
        send(OWN, 16'h8808, 16'h0001, 16'h0004, 64, 1'b1, 0);
        send(OWN, 16'h8808, 16'h0001, 16'h0000, 64, 1'b1, 0);
        wait_run(base, "R10 zero releases", 129);

        // R11 R12 transmit gating during a pause
        base = runs;
        send(MC, 16'h8808, 16'h0001, 16'h0002, 64, 1'b1, 0);
        repeat (5) @(negedge clk);
        tx_norm_req = 1'b1; tx_oos_req = 1'b1;
        #1;
        chk(tx_norm_ok == 1'b0, "R11 norm blocked in pause", int'(tx_norm_ok), 0);
        chk(tx_oos_ok == 1'b1, "R12 first oos in pause", int'(tx_oos_ok), 1);
        @(negedge clk);
        chk(tx_oos_ok == 1'b0, "R12 second oos refused", int'(tx_oos_ok), 0);
        tx_oos_req = 1'b0;
        repeat (20) @(negedge clk);
        tx_oos_req = 1'b1;
        #1;
        chk(tx_oos_ok == 1'b0, "R12 later oos refused", int'(tx_oos_ok), 0);
        tx_oos_req = 1'b0; tx_norm_req = 1'b0;
        wait_run(base, "R8 pause with tx traffic", 2 * SLOT);
        tx_norm_req = 1'b1; tx_oos_req = 1'b1;
        #1;
        chk(tx_norm_ok == 1'b1, "R11 norm after pause", int'(tx_norm_ok), 1);
        chk(tx_oos_ok == 1'b1, "R12 oos after pause", int'(tx_oos_ok), 1);
        tx_norm_req = 1'b0; tx_oos_req = 1'b0;

        finish_run();
    end
endmodule